// File: doc/BRIEF.md
# MDIO Management Frame Master

This block produces complete read and write frames on the Ethernet MII management serial line, one bit at a time. A requester presents a one-cycle request with an operation flag, a 5-bit PHY address, a 5-bit register number and, for a write, a 16-bit data word. The block then generates the management clock, the data output and its output enable, and it samples the data input from the PHY.

The management clock is derived from the system clock. Each clock phase, low or high, lasts `HALF_CLKS` system clocks. The output side changes only while the management clock is low. The input is captured at the end of each high phase. When the frame ends, `done` pulses for one cycle and `busy` drops. After a read, `rdata` holds the assembled word. Only one request is handled at a time.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc`, `mdo`, `mdo_en`, `busy` and `done` are all low. Whenever `mdo_en` is low, `mdo` is low.
- R2: Every frame opens with 32 bit times of `mdo`=1 with `mdo_en`=1 (bit times 0 to 31).
- R3: Bit times 32 and 33 carry 0 then 1. Bit times 34 and 35 carry the operation code: 1,0 for a read and 0,1 for a write. All four are driven.
- R4: Bit times 36 to 40 carry the PHY address and bit times 41 to 45 carry the register number. Both are driven most significant bit first.
- R5: A read releases the line (`mdo_en`=0) at bit time 46. It keeps the line released during bit times 47 to 62 and samples `mdi` in each of them. The bit sampled at time 47 becomes bit 15 of `rdata`. `rdata` is valid from the `done` cycle and changes only when a later read completes.
- R6: A write releases the line at bit times 46 and 47. It then drives the 16 data bits at bit times 48 to 63, most significant bit first.
- R7: The last bit time of every frame has `mdo_en`=0. A read frame has exactly 64 bit times and a write frame has exactly 65.
- R8: `mdo` and `mdo_en` hold steady for the whole high phase of `mdc`. `mdi` is taken at the end of the high phase.
- R9: Each `mdc` phase lasts `HALF_CLKS` system clocks (minimum 1). `busy` is therefore high for exactly bits × 2 × `HALF_CLKS` cycles.
- R10: `busy` rises in the cycle after a request is accepted. `done` is a single-cycle pulse in which `busy` is already low.
- R11: A request presented while `busy` is high has no effect. The frame in progress is unchanged, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Data assembled by the last read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data out |
| mdo_en | output | 1 | Output enable for the shared data line |
| mdi | input | 1 | Management data in |

## Verification
The hardest situation to reach from the ports is a second request arriving in the middle of a frame. The bench raises one partway through a read, with every field changed. It then checks that the serial bit stream and the read result still match the original request, and that `busy` stays low after `done`. The bench also holds `mdi` at 1 outside the read data window. A design that samples one bit time early or late would then pull stray ones into `rdata`.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CLKS = 2,
  parameter int PRE_BITS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_en,
  input  logic        mdi
);

  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int BW = $clog2(PRE_BITS + 33);
  localparam logic [CW-1:0] CNT_END = CW'(HALF_CLKS - 1);
  localparam logic [BW-1:0] ST     = BW'(PRE_BITS);
  localparam logic [BW-1:0] OPB    = BW'(PRE_BITS + 2);
  localparam logic [BW-1:0] PA     = BW'(PRE_BITS + 4);
  localparam logic [BW-1:0] RA     = BW'(PRE_BITS + 9);
  localparam logic [BW-1:0] RA_M1  = BW'(PRE_BITS + 8);
  localparam logic [BW-1:0] TA     = BW'(PRE_BITS + 14);
  localparam logic [BW-1:0] TA_M1  = BW'(PRE_BITS + 13);
  localparam logic [BW-1:0] RD0    = BW'(PRE_BITS + 15);
  localparam logic [BW-1:0] RDL    = BW'(PRE_BITS + 31);
  localparam logic [BW-1:0] WD0    = BW'(PRE_BITS + 16);
  localparam logic [BW-1:0] WDL    = BW'(PRE_BITS + 32);
  localparam logic [BW-1:0] WDL_M1 = BW'(PRE_BITS + 31);

  logic          wr_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   wd_q, sh_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic          phase;
  logic          bo, be;

  wire half_end = (cnt == CNT_END);
  wire in_rd    = !wr_q && (bidx >= RD0) && (bidx < RDL);
  wire is_last  = wr_q ? (bidx == WDL) : (bidx == RDL);

  always_comb begin
    bo = 1'b0;
    be = 1'b0;
    if (bidx < ST) begin
      bo = 1'b1; be = 1'b1;
    end else if (bidx == ST) begin
      be = 1'b1;
    end else if (bidx == ST + 1'b1) begin
      bo = 1'b1; be = 1'b1;
    end else if (bidx == OPB) begin
      bo = !wr_q; be = 1'b1;
    end else if (bidx == OPB + 1'b1) begin
      bo = wr_q; be = 1'b1;
    end else if (bidx >= PA && bidx < RA) begin
      bo = phy_q[3'(RA_M1 - bidx)]; be = 1'b1;
    end else if (bidx >= RA && bidx < TA) begin
      bo = reg_q[3'(TA_M1 - bidx)]; be = 1'b1;
    end else if (wr_q && bidx >= WD0 && bidx < WDL) begin
      bo = wd_q[4'(WDL_M1 - bidx)]; be = 1'b1;
    end
  end

  assign mdc    = phase;
  assign mdo    = busy & be & bo;
  assign mdo_en = busy & be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
      sh_q  <= '0;
      wr_q  <= 1'b0;
      phy_q <= '0;
      reg_q <= '0;
      wd_q  <= '0;
      cnt   <= '0;
      bidx  <= '0;
      phase <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy  <= 1'b1;
          wr_q  <= req_write;
          phy_q <= req_phy;
          reg_q <= req_reg;
          wd_q  <= req_wdata;
          cnt   <= '0;
          bidx  <= '0;
          phase <= 1'b0;
        end
      end else if (!half_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (in_rd) sh_q <= {sh_q[14:0], mdi};
          if (is_last) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (!wr_q) rdata <= sh_q;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdo && !mdo_en));

  // R1
  drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdo |-> mdo_en);

  // R8
  high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_en)));

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({wr_q, phy_q, reg_q, wd_q}));

endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdo, mdo_en;
  logic mdi = 1'b1;
  logic [15:0] rdata;

  int checks = 0, errors = 0;
  int nb = 0, busy_cnt = 0, done_cnt = 0, hi_viol = 0;
  logic cur_wr = 1'b0;
  logic [15:0] phy_val = '0;
  logic cap_o [0:79];
  logic cap_e [0:79];

  always #4 clk = ~clk;

  mdio_master #(.HALF_CLKS(HALF), .PRE_BITS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mdc(mdc), .mdo(mdo),
    .mdo_en(mdo_en), .mdi(mdi));

  localparam logic [26:0] VEC [6] = '{
    {1'b1, 5'h1F, 5'h00, 16'hA5C3},
    {1'b0, 5'h00, 5'h1F, 16'h8001},
    {1'b1, 5'h12, 5'h0D, 16'h0000},
    {1'b0, 5'h0A, 5'h15, 16'hFFFF},
    {1'b0, 5'h01, 5'h02, 16'h1234},
    {1'b1, 5'h15, 5'h0A, 16'hFFFF}
  };

  always @(posedge mdc) begin
    #1;
    if (nb < 80) begin
      cap_o[nb] = mdo;
      cap_e[nb] = mdo_en;
    end
    nb = nb + 1;
  end

  always @(negedge mdc) begin
    #1;
    if (!cur_wr && nb >= 47 && nb < 63) mdi = phy_val[15 - (nb - 47)];
    else mdi = 1'b1;
  end

  always @(negedge clk) begin
    if (busy) busy_cnt = busy_cnt + 1;
    if (done) done_cnt = done_cnt + 1;
    if (mdc && nb > 0 && nb <= 80 && mdo !== cap_o[nb-1]) hi_viol = hi_viol + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_range(input logic eo [0:79], input logic ee [0:79],
                           input int lo, input int hi, input string req);
    int bad = -1;
    for (int i = lo; i < hi; i++)
      if (bad < 0 && (cap_o[i] !== eo[i] || cap_e[i] !== ee[i])) bad = i;
    if (bad < 0) chk(1'b1, req, "bits", 0, 0);
    else chk(1'b0, req, $sformatf("bit %0d {mdo,en}", bad),
             {cap_o[bad], cap_e[bad]}, {eo[bad], ee[bad]});
  endtask

  task automatic run_frame(input logic wr, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [15:0] d,
                           input bit inject);
    logic eo [0:79];
    logic ee [0:79];
    logic [15:0] rd_before;
    int bits = wr ? 65 : 64;
    for (int i = 0; i < 80; i++) begin eo[i] = 1'b0; ee[i] = 1'b0; end
    for (int i = 0; i < 32; i++) begin eo[i] = 1'b1; ee[i] = 1'b1; end
    eo[32] = 0; eo[33] = 1; eo[34] = !wr; eo[35] = wr;
    for (int i = 32; i < 46; i++) ee[i] = 1'b1;
    for (int i = 0; i < 5; i++) begin eo[36+i] = pa[4-i]; eo[41+i] = ra[4-i]; end
    if (wr) for (int i = 0; i < 16; i++) begin eo[48+i] = d[15-i]; ee[48+i] = 1'b1; end

    @(negedge clk);
    rd_before = rdata;
    nb = 0; busy_cnt = 0; done_cnt = 0; hi_viol = 0;
    cur_wr = wr; phy_val = d;
    req_valid = 1'b1; req_write = wr; req_phy = pa; req_reg = ra; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R10", "busy after accept", busy, 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_write = !wr; req_phy = ~pa; req_reg = ~ra; req_wdata = ~d;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy in done cycle", busy, 0);
    if (!wr) chk(rdata === d, "R5", "rdata", rdata, d);
    else chk(rdata === rd_before, "R5", "rdata kept on write", rdata, rd_before);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done width", done, 0);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && mdc === 1'b0 && mdo === 1'b0 && mdo_en === 1'b0,
        inject ? "R11" : "R1", "idle after frame", {busy, mdc, mdo, mdo_en}, 0);
    chk(nb == bits, "R7", "bit times", nb, bits);
    chk(busy_cnt == bits * 2 * HALF, "R9", "busy cycles", busy_cnt, bits * 2 * HALF);
    chk(done_cnt == 1, "R10", "done count", done_cnt, 1);
    chk(hi_viol == 0, "R8", "mdo moved in high phase", hi_viol, 0);
    cmp_range(eo, ee, 0, 32, "R2");
    cmp_range(eo, ee, 32, 36, "R3");
    cmp_range(eo, ee, 36, 46, "R4");
    if (wr) cmp_range(eo, ee, 46, 64, "R6");
    else cmp_range(eo, ee, 46, 63, "R5");
    cmp_range(eo, ee, bits - 1, bits, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, mdc, mdo, mdo_en} === 5'b0, "R1", "reset state",
        {busy, done, mdc, mdo, mdo_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, mdc, mdo, mdo_en} === 5'b0, "R1", "idle after reset",
        {busy, done, mdc, mdo, mdo_en}, 0);
    foreach (VEC[k]) run_frame(VEC[k][26], VEC[k][25:21], VEC[k][20:16], VEC[k][15:0], 1'b0);
    // R11: a second request during a read frame
    run_frame(1'b0, 5'h0C, 5'h11, 16'h5AA5, 1'b1);
    // R11: a second request during a write frame
    run_frame(1'b1, 5'h03, 5'h1C, 16'hC3C3, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule